// File: doc/BRIEF.md
# Instruction Store Programming Port with Split Parity

This block owns a small per-engine instruction store and the register port a host uses to fill it. The host writes the address register with the top bit set to enter programming mode and to pick a starting slot. It then loads each instruction in two pieces. The first piece is a 32-bit lower word, which is only staged. The second is an upper word, which commits the full stored word into the current slot and steps the slot index by one. The index wraps to slot zero after the last slot. Writing the address register with the top bit clear ends programming.

Each stored word has 42 bits. Bits 39:0 hold the instruction. Bit 40 is even parity over bits 19:0, and bit 41 is even parity over bits 39:20. The host supplies both parity bits in the upper word, so the store keeps them exactly as written. An engine-side fetch port reads one slot per request and returns it one cycle later. When the parity-check enable is set, the block compares the stored parity bits against the instruction bits on every fetch. A mismatch raises a one-cycle error and sets a sticky flag, which the host clears by writing 1 to it.

Top module: `ustore_prog_port`

## Requirements
- R1: After reset the block is out of programming mode, and the address, control and status registers (selects 0, 3 and 4) all read 0.
- R2: Writing the address register (select 0) with bit 31 set enters programming mode and loads the index from the low IDX_W bits. The register then reads back as bit 31 set with the index in its low bits.
- R3: Writing the address register with bit 31 clear leaves programming mode and clears the index, so the register reads 0.
- R4: In programming mode, a write to the lower data register (select 1) stages 32 bits. A later write to the upper data register (select 2) stores {upper[9:0], staged} at the current index and advances the index by one.
- R5: Several lower-word writes with no upper write in between leave only the last of them staged, and that is the value committed.
- R6: A commit at index DEPTH-1 wraps the index to 0, so the address register then reads 0x8000_0000.
- R7: Outside programming mode, writes to the lower and upper data registers change neither the store, nor the staged word, nor the index.
- R8: A fetch request on fetch_req_i with a slot index returns fetch_valid_o high and the full 42-bit stored word on fetch_word_o in the next cycle.
- R9: With parity checking enabled (control register bit 28), a fetched word is in error when bit 40 differs from the XOR of bits 19:0 or bit 41 differs from the XOR of bits 39:20. An error pulses fetch_perr_o with fetch_valid_o, and one cycle later the sticky flag (status bit 0, also perr_sticky_o) is set.
- R10: With parity checking disabled, fetch_perr_o stays low and the sticky flag is not set, whatever the fetched word holds.
- R11: The sticky flag holds until the status register is written with bit 0 set. A write with bit 0 clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select (0 address, 1 lower data, 2 upper data, 3 control, 4 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| fetch_req_i | input | 1 | Fetch request |
| fetch_idx_i | input | IDX_W (10) | Slot to fetch |
| fetch_valid_o | output | 1 | Fetch data valid, one cycle after the request |
| fetch_word_o | output | 42 | Fetched word: parity bits 41:40, instruction bits 39:0 |
| fetch_perr_o | output | 1 | Parity error on the current fetch |
| perr_sticky_o | output | 1 | Sticky parity error flag |

## Verification
The bench builds the block with DEPTH set to 16, which gives a 4-bit index. At that size, walking the index from a programmed start up to the last slot and across the wrap to slot zero takes only a handful of commits. It also keeps the address readback at the wrap point short enough to compare against 0x8000_0000 directly. The parity cases use words with deliberately wrong parity bits, and they run with the check both disabled and enabled.

// File: rtl/ustore_pkg.sv
package ustore_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_DLO  = 3'd1,
    SEL_DHI  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;

  localparam int PROG_BIT   = 31;
  localparam int PAR_EN_BIT = 28;
  localparam int PERR_BIT   = 0;
  localparam int REG_W      = 32;
endpackage

// File: rtl/ustore_regs.sv
module ustore_regs
  import ustore_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int IDX_W   = 10,
  parameter int STORE_W = 42
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         sel_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               perr_set_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               prog_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               mem_we_o,
  output logic [IDX_W-1:0]   mem_waddr_o,
  output logic [STORE_W-1:0] mem_wdata_o,
  output logic               par_en_o,
  output logic               sticky_o
);
  localparam int HI_W = STORE_W - REG_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  reg_sel_e sel;
  logic wr_addr, wr_dlo, wr_dhi, wr_ctrl, wr_stat, commit;
  logic prog_q, par_en_q, sticky_q;
  logic [IDX_W-1:0] idx_q;
  logic [REG_W-1:0] stage_q;

  assign sel     = reg_sel_e'(sel_i);
  assign wr_addr = we_i && (sel == SEL_ADDR);
  assign wr_dlo  = we_i && (sel == SEL_DLO) && prog_q;
  assign wr_dhi  = we_i && (sel == SEL_DHI);
  assign wr_ctrl = we_i && (sel == SEL_CTRL);
  assign wr_stat = we_i && (sel == SEL_STAT);
  assign commit  = wr_dhi && prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= 1'b0;
      idx_q  <= '0;
    end else if (wr_addr) begin
      prog_q <= wdata_i[PROG_BIT];
      idx_q  <= wdata_i[PROG_BIT] ? wdata_i[IDX_W-1:0] : '0;
    end else if (commit) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (wr_dlo) stage_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      par_en_q <= 1'b0;
    else if (wr_ctrl) par_en_q <= wdata_i[PAR_EN_BIT];
  end

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            sticky_q <= 1'b0;
    else if (perr_set_i)                    sticky_q <= 1'b1;
    else if (wr_stat && wdata_i[PERR_BIT])  sticky_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_ADDR: begin
        rdata_o[PROG_BIT]  = prog_q;
        rdata_o[IDX_W-1:0] = idx_q;
      end
      SEL_DLO:  rdata_o = stage_q;
      SEL_CTRL: rdata_o[PAR_EN_BIT] = par_en_q;
      SEL_STAT: rdata_o[PERR_BIT] = sticky_q;
      default:  rdata_o = '0;
    endcase
  end

  assign mem_we_o    = commit;
  assign mem_waddr_o = idx_q;
  assign mem_wdata_o = {wdata_i[HI_W-1:0], stage_q};
  assign prog_o      = prog_q;
  assign idx_o       = idx_q;
  assign par_en_o    = par_en_q;
  assign sticky_o    = sticky_q;
endmodule

// File: rtl/ustore_mem.sv
module ustore_mem #(
  parameter int DEPTH = 1024,
  parameter int IDX_W = 10,
  parameter int W     = 42
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic             rvalid_o,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rdata_q;
  logic         rvalid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) rdata_q <= mem_q[raddr_i];
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/ustore_par_chk.sv
module ustore_par_chk #(
  parameter int INSN_W = 40,
  parameter int GROUPS = 2
) (
  input  logic [INSN_W+GROUPS-1:0] word_i,
  output logic                     bad_o
);
  localparam int GRP_W = INSN_W / GROUPS;

  logic [GROUPS-1:0] calc;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign calc[g] = ^word_i[g*GRP_W +: GRP_W];
  end

  assign bad_o = |(calc ^ word_i[INSN_W +: GROUPS]);
endmodule

// File: rtl/ustore_prog_port.sv
module ustore_prog_port
  import ustore_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int INSN_W = 40,
  parameter int GROUPS = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int STORE_W = INSN_W + GROUPS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               fetch_req_i,
  input  logic [IDX_W-1:0]   fetch_idx_i,
  output logic               fetch_valid_o,
  output logic [STORE_W-1:0] fetch_word_o,
  output logic               fetch_perr_o,
  output logic               perr_sticky_o
);
  logic               prog, mem_we, par_en, bad;
  logic [IDX_W-1:0]   idx, mem_waddr;
  logic [STORE_W-1:0] mem_wdata;

  ustore_regs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .STORE_W(STORE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .perr_set_i  (fetch_perr_o),
    .rdata_o     (reg_rdata_o),
    .prog_o      (prog),
    .idx_o       (idx),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata),
    .par_en_o    (par_en),
    .sticky_o    (perr_sticky_o)
  );

  ustore_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .W(STORE_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mem_we),
    .waddr_i  (mem_waddr),
    .wdata_i  (mem_wdata),
    .re_i     (fetch_req_i),
    .raddr_i  (fetch_idx_i),
    .rvalid_o (fetch_valid_o),
    .rdata_o  (fetch_word_o)
  );

  ustore_par_chk #(.INSN_W(INSN_W), .GROUPS(GROUPS)) u_par (
    .word_i (fetch_word_o),
    .bad_o  (bad)
  );

  assign fetch_perr_o = fetch_valid_o && par_en && bad;
endmodule

// File: rtl/ustore_prog_port_chk.sv
module ustore_prog_port_chk #(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_sel_i,
  input logic [31:0]      reg_wdata_i,
  input logic             fetch_req_i,
  input logic             fetch_valid_o,
  input logic             fetch_perr_o,
  input logic             perr_sticky_o,
  input logic             prog,
  input logic [IDX_W-1:0] idx,
  input logic             mem_we,
  input logic             par_en
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  a_r2_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 3'd0 && reg_wdata_i[31]) |=> (prog && idx == $past(reg_wdata_i[IDX_W-1:0])));

  a_r3_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 3'd0 && !reg_wdata_i[31]) |=> (!prog && idx == '0));

  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog && reg_we_i && reg_sel_i == 3'd2 && idx != LAST) |=> (idx == $past(idx) + 1'b1));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog && reg_we_i && reg_sel_i == 3'd2 && idx == LAST) |=> (idx == '0 && prog));

  a_r7_no_commit_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog |-> !mem_we);

  a_r7_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog && !(reg_we_i && reg_sel_i == 3'd0)) |=> $stable(idx));

  a_r8_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i |=> fetch_valid_o);

  a_r9_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_perr_o |=> perr_sticky_o);

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_en || !fetch_valid_o) |-> !fetch_perr_o);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_sticky_o && !(reg_we_i && reg_sel_i == 3'd4 && reg_wdata_i[0])) |=> perr_sticky_o);
endmodule

bind ustore_prog_port ustore_prog_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_sel_i     (reg_sel_i),
  .reg_wdata_i   (reg_wdata_i),
  .fetch_req_i   (fetch_req_i),
  .fetch_valid_o (fetch_valid_o),
  .fetch_perr_o  (fetch_perr_o),
  .perr_sticky_o (perr_sticky_o),
  .prog          (prog),
  .idx           (idx),
  .mem_we        (mem_we),
  .par_en        (par_en)
);

// File: tb/ustore_prog_port_tb.sv
module ustore_prog_port_tb;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        fetch_req_i = 1'b0;
  logic [IDX_W-1:0] fetch_idx_i = '0;
  logic        fetch_valid_o;
  logic [41:0] fetch_word_o;
  logic        fetch_perr_o;
  logic        perr_sticky_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ustore_prog_port #(.DEPTH(DEPTH)) u_dut (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .fetch_req_i, .fetch_idx_i, .fetch_valid_o, .fetch_word_o,
    .fetch_perr_o, .perr_sticky_o
  );

  function automatic logic [41:0] mk(input logic [39:0] insn);
    return {^insn[39:20], ^insn[19:0], insn};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  // returns after the valid cycle has begun; sample immediately
  task automatic fetch(input logic [IDX_W-1:0] i);
    @(negedge clk_i);
    fetch_req_i = 1'b1; fetch_idx_i = i;
    @(negedge clk_i);
    fetch_req_i = 1'b0;
  endtask

  task automatic put(input logic [41:0] w);
    wr(3'd1, w[31:0]);
    wr(3'd2, {22'd0, w[41:32]});
  endtask

  logic [41:0] w5, w6, w15, w0, bad3;

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 addr", d, 0);
    rd(3'd3, d); chk("R1 ctrl", d, 0);
    rd(3'd4, d); chk("R1 status", d, 0);
    chk("R1 valid", fetch_valid_o, 0);
  endtask

  task automatic t_enter_commit;
    logic [31:0] d;
    wr(3'd0, 32'h8000_0005);
    rd(3'd0, d); chk("R2 addr readback", d, 32'h8000_0005);
    w5 = mk(40'hA5_1234_5678);
    put(w5);
    rd(3'd0, d); chk("R4 index advance", d, 32'h8000_0006);
    fetch(4'd5);
    chk("R8 valid", fetch_valid_o, 1);
    chk("R4 R8 stored word", fetch_word_o, w5);
  endtask

  task automatic t_overwrite;
    logic [31:0] d;
    w6 = mk(40'h3C_0BAD_F00D);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd1, w6[31:0]);
    rd(3'd1, d); chk("R5 staged last", d, w6[31:0]);
    wr(3'd2, {22'd0, w6[41:32]});
    fetch(4'd6);
    chk("R5 committed last lower", fetch_word_o, w6);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(3'd0, 32'h8000_000F);
    w15 = mk(40'h11_2222_3333);
    put(w15);
    rd(3'd0, d); chk("R6 wrap readback", d, 32'h8000_0000);
    w0 = mk(40'h77_0000_0001);
    put(w0);
    rd(3'd0, d); chk("R6 after wrap", d, 32'h8000_0001);
    fetch(4'd0);
    chk("R6 slot0 word", fetch_word_o, w0);
    fetch(4'd15);
    chk("R6 last slot word", fetch_word_o, w15);
  endtask

  task automatic t_exit_ignore;
    logic [31:0] d;
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R3 exit readback", d, 0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_03FF);
    rd(3'd1, d); chk("R7 stage unchanged", d, w0[31:0]);
    rd(3'd0, d); chk("R7 index unchanged", d, 0);
    fetch(4'd0);
    chk("R7 slot0 unchanged", fetch_word_o, w0);
  endtask

  task automatic t_parity;
    logic [31:0] d;
    bad3 = mk(40'h01_0000_0001) ^ 42'h100_0000_0000; // flip bit 40
    wr(3'd0, 32'h8000_0003);
    put(bad3);
    wr(3'd0, 32'h0);
    fetch(4'd3);
    chk("R10 no perr disabled", fetch_perr_o, 0);
    chk("R9 raw word kept", fetch_word_o, bad3);
    @(negedge clk_i);
    rd(3'd4, d); chk("R10 sticky clear", d, 0);
    wr(3'd3, 32'h1000_0000);
    rd(3'd3, d); chk("R9 ctrl readback", d, 32'h1000_0000);
    fetch(4'd5);
    chk("R9 good word no perr", fetch_perr_o, 0);
    fetch(4'd3);
    chk("R9 perr pulse", fetch_perr_o, 1);
    @(negedge clk_i);
    chk("R9 perr one cycle", fetch_perr_o, 0);
    rd(3'd4, d); chk("R9 sticky set", d, 1);
    wr(3'd4, 32'h0);
    rd(3'd4, d); chk("R11 write 0 keeps", d, 1);
    wr(3'd4, 32'h1);
    rd(3'd4, d); chk("R11 write 1 clears", d, 0);
    chk("R11 sticky port", perr_sticky_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_enter_commit();
    t_overwrite();
    t_wrap();
    t_exit_ignore();
    t_parity();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule